// File: doc/BRIEF.md
# Reactive-Associative Cache Lookup Controller

This block performs lookups in a small cache whose single data array is addressed in two ways at once. Every line address has a fixed direct-mapped home. That home is one particular way of its set. The same line may also sit in any way of that set under set-associative placement. A request carries a line address and a way guess from an outside predictor. In the acceptance cycle, the first probe tests three things together: the home way, the guessed way, and the tags of every way of the set.

A hit in the home way or the guessed way is answered in the next cycle. If only the parallel tag search finds the line, the controller spends one more cycle on a second probe, which reads the data array at the way that matched. If nothing matches, the controller reports a miss and raises a fill request. It then waits for a fill handshake, which writes the line at its home way or at a way the caller chooses.

Top module: `rac_lookup`

## Requirements
- R1: After reset, every tag entry is invalid, `req_ready_o` is 1, and `resp_valid_o` and `miss_valid_o` are 0. Any lookup made after a reset misses.
- R2: The address fields are: set = `req_addr_i[SET_W-1:0]`, home way = `req_addr_i[SET_W+WAY_W-1:SET_W]`, tag = `req_addr_i[ADDR_W-1:SET_W]`. A valid tag match in the home way gives `resp_valid_o` with `hit_dm_o` and the line data in the cycle after acceptance.
- R3: If the home way does not match and the way in `req_pred_way_i` does, `hit_pred_o` and the data follow in the cycle after acceptance.
- R4: A match in the home way takes priority over the guessed way. This includes the case where the guess equals the home way.
- R5: If only the parallel tag search finds the line, `req_ready_o` is 0 for one cycle. `resp_valid_o` with `hit_probe1_o` and the data from the matching way follow two cycles after acceptance.
- R6: If no way matches, `resp_valid_o` with `miss_o` follows in the cycle after acceptance. `miss_valid_o` then stays high and `req_ready_o` stays low until `fill_valid_i` is seen.
- R7: If `fill_assoc_i` is 0, a fill writes the line, its tag and its valid bit at the home way of the missed address.
- R8: If `fill_assoc_i` is 1, a fill writes the line at way `fill_way_i`. Any line already there is replaced.
- R9: When `resp_valid_o` is 1, exactly one of `hit_dm_o`, `hit_pred_o`, `hit_probe1_o`, `miss_o` is 1. When `resp_valid_o` is 0, all four are 0.
- R10: A request made while `req_ready_o` is 0 is ignored. A `fill_valid_i` pulse made while `miss_valid_o` is 0 writes nothing.
- R11: While `miss_valid_o` is 1, `miss_addr_o` holds the address of the request that missed.
- R12: The tag compare uses every address bit above the set field. Two addresses with the same set and the same home way but different upper bits do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_addr_i | input | ADDR_W | Line address of the request |
| req_pred_way_i | input | WAY_W | Way guess from the predictor |
| resp_valid_o | output | 1 | Response strobe |
| resp_data_o | output | DATA_W | Line data on a hit |
| hit_dm_o | output | 1 | Hit in the home way |
| hit_pred_o | output | 1 | Hit in the guessed way |
| hit_probe1_o | output | 1 | Hit resolved by the second probe |
| miss_o | output | 1 | Lookup missed |
| miss_valid_o | output | 1 | Fill requested, waiting for fill |
| miss_addr_o | output | ADDR_W | Address to fill |
| fill_valid_i | input | 1 | Fill handshake |
| fill_data_i | input | DATA_W | Fill line data |
| fill_assoc_i | input | 1 | 1: place at fill_way_i, 0: place at home way |
| fill_way_i | input | WAY_W | Way chosen for associative placement |

## Verification
The bench places lines off their home way, so the guessed-way path and the second-probe path are both taken for one address. A design that ignored the guess would report a second probe where a one-cycle hit is due. It also uses a guess equal to the home way, and a guess pointing at a way that holds a different tag of the same set. A design with the wrong priority, or one that trusted the guess without comparing tags, would flag the wrong path or return the wrong data. An aliasing address shares set and home way with a stored line but differs in its upper bits. It must miss, and a design that compared only part of the tag would hit. The bench also makes requests during a pending fill, sends a fill pulse while idle, and resets in the middle of the run. A design that let any of these through would produce a response that should not exist, corrupt a stored line, or keep stale lines after reset.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PROBE1, ST_FILL} rac_state_e;
  typedef enum logic [1:0] {RES_DM, RES_PRED, RES_PROBE1, RES_MISS} rac_res_e;
endpackage

// File: rtl/rac_tag_banks.sv
module rac_tag_banks #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int TAG_W = 9,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  match_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else if (sel) vld_q[wr_set_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[wr_set_i] <= wr_tag_i;
    end

    // every bank compares in parallel
    assign match_o[w] = vld_q[lk_set_i] && (tag_q[lk_set_i] == lk_tag_i);
  end
endmodule

// File: rtl/rac_data_array.sv
module rac_data_array #(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int DATA_W = 32,
  localparam int LINES  = WAYS * SETS,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic [LINE_W-1:0] rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [LINE_W-1:0] rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_a_data_o = mem_q[rd_a_idx_i];
  assign rd_b_data_o = mem_q[rd_b_idx_i];
endmodule

// File: rtl/rac_probe_ctrl.sv
module rac_probe_ctrl
  import rac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int LINE_W = WAY_W + SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WAY_W-1:0]  req_pred_way_i,
  output logic [SET_W-1:0]  lk_set_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  input  logic [WAYS-1:0]   match_i,
  output logic [LINE_W-1:0] rd_a_idx_o,
  output logic [LINE_W-1:0] rd_b_idx_o,
  input  logic [DATA_W-1:0] rd_a_data_i,
  input  logic [DATA_W-1:0] rd_b_data_i,
  output logic              wr_en_o,
  output logic [WAY_W-1:0]  wr_way_o,
  output logic [SET_W-1:0]  wr_set_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output rac_res_e          resp_kind_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  input  logic              fill_valid_i,
  input  logic              fill_assoc_i,
  input  logic [WAY_W-1:0]  fill_way_i
);
  rac_state_e        state_q, state_d;
  logic [WAY_W-1:0]  p1_way_q;
  logic [SET_W-1:0]  p1_set_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              resp_valid_q;
  rac_res_e          resp_kind_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [SET_W-1:0]  req_set;
  logic [WAY_W-1:0]  home_way;
  logic [WAY_W-1:0]  bank_way;
  logic              accept, dm_hit, pred_hit, any_hit;

  assign req_set  = req_addr_i[SET_W-1:0];
  assign home_way = req_addr_i[SET_W +: WAY_W];
  assign lk_set_o = req_set;
  assign lk_tag_o = req_addr_i[ADDR_W-1:SET_W];

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign dm_hit   = match_i[home_way];
  assign pred_hit = match_i[req_pred_way_i];
  assign any_hit  = |match_i;

  always_comb begin
    bank_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) bank_way = WAY_W'(w);
    end
  end

  // port A: home slot on probe 0, bank-resolved slot on probe 1
  assign rd_a_idx_o = (state_q == ST_PROBE1) ? {p1_way_q, p1_set_q} : {home_way, req_set};
  assign rd_b_idx_o = {req_pred_way_i, req_set};

  assign wr_en_o  = (state_q == ST_FILL) && fill_valid_i;
  assign wr_way_o = fill_assoc_i ? fill_way_i : miss_addr_q[SET_W +: WAY_W];
  assign wr_set_o = miss_addr_q[SET_W-1:0];
  assign wr_tag_o = miss_addr_q[ADDR_W-1:SET_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !dm_hit && !pred_hit) state_d = any_hit ? ST_PROBE1 : ST_FILL;
      end
      ST_PROBE1: state_d = ST_IDLE;
      ST_FILL:   if (fill_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      p1_way_q     <= '0;
      p1_set_q     <= '0;
      miss_addr_q  <= '0;
      resp_valid_q <= 1'b0;
      resp_kind_q  <= RES_MISS;
      resp_data_q  <= '0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= 1'b0;
      if (state_q == ST_PROBE1) begin
        resp_valid_q <= 1'b1;
        resp_kind_q  <= RES_PROBE1;
        resp_data_q  <= rd_a_data_i;
      end else if (accept) begin
        if (dm_hit) begin
          resp_valid_q <= 1'b1;
          resp_kind_q  <= RES_DM;
          resp_data_q  <= rd_a_data_i;
        end else if (pred_hit) begin
          resp_valid_q <= 1'b1;
          resp_kind_q  <= RES_PRED;
          resp_data_q  <= rd_b_data_i;
        end else if (any_hit) begin
          p1_way_q <= bank_way;
          p1_set_q <= req_set;
        end else begin
          resp_valid_q <= 1'b1;
          resp_kind_q  <= RES_MISS;
          resp_data_q  <= '0;
          miss_addr_q  <= req_addr_i;
        end
      end
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = resp_valid_q;
  assign resp_kind_o  = resp_kind_q;
  assign resp_data_o  = resp_data_q;
  assign miss_valid_o = (state_q == ST_FILL);
  assign miss_addr_o  = miss_addr_q;
endmodule

// File: rtl/rac_lookup.sv
module rac_lookup
  import rac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WAY_W-1:0]  req_pred_way_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              hit_dm_o,
  output logic              hit_pred_o,
  output logic              hit_probe1_o,
  output logic              miss_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_assoc_i,
  input  logic [WAY_W-1:0]  fill_way_i
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int LINE_W = WAY_W + SET_W;

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   match;
  logic [LINE_W-1:0] rd_a_idx, rd_b_idx;
  logic [DATA_W-1:0] rd_a_data, rd_b_data;
  logic              wr_en;
  logic [WAY_W-1:0]  wr_way;
  logic [SET_W-1:0]  wr_set;
  logic [TAG_W-1:0]  wr_tag;
  logic              resp_valid;
  rac_res_e          resp_kind;

  rac_tag_banks #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_set_i (lk_set),
    .lk_tag_i (lk_tag),
    .match_o  (match),
    .wr_en_i  (wr_en),
    .wr_way_i (wr_way),
    .wr_set_i (wr_set),
    .wr_tag_i (wr_tag)
  );

  rac_data_array #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .rd_a_idx_i  (rd_a_idx),
    .rd_a_data_o (rd_a_data),
    .rd_b_idx_i  (rd_b_idx),
    .rd_b_data_o (rd_b_data),
    .wr_en_i     (wr_en),
    .wr_idx_i    ({wr_way, wr_set}),
    .wr_data_i   (fill_data_i)
  );

  rac_probe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_addr_i     (req_addr_i),
    .req_pred_way_i (req_pred_way_i),
    .lk_set_o       (lk_set),
    .lk_tag_o       (lk_tag),
    .match_i        (match),
    .rd_a_idx_o     (rd_a_idx),
    .rd_b_idx_o     (rd_b_idx),
    .rd_a_data_i    (rd_a_data),
    .rd_b_data_i    (rd_b_data),
    .wr_en_o        (wr_en),
    .wr_way_o       (wr_way),
    .wr_set_o       (wr_set),
    .wr_tag_o       (wr_tag),
    .resp_valid_o   (resp_valid),
    .resp_data_o    (resp_data_o),
    .resp_kind_o    (resp_kind),
    .miss_valid_o   (miss_valid_o),
    .miss_addr_o    (miss_addr_o),
    .fill_valid_i   (fill_valid_i),
    .fill_assoc_i   (fill_assoc_i),
    .fill_way_i     (fill_way_i)
  );

  assign resp_valid_o = resp_valid;
  assign hit_dm_o     = resp_valid && (resp_kind == RES_DM);
  assign hit_pred_o   = resp_valid && (resp_kind == RES_PRED);
  assign hit_probe1_o = resp_valid && (resp_kind == RES_PROBE1);
  assign miss_o       = resp_valid && (resp_kind == RES_MISS);
endmodule

// File: rtl/rac_lookup_chk.sv
module rac_lookup_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              resp_valid_o,
  input logic              hit_dm_o,
  input logic              hit_pred_o,
  input logic              hit_probe1_o,
  input logic              miss_o,
  input logic              miss_valid_o,
  input logic [ADDR_W-1:0] miss_addr_o,
  input logic              fill_valid_i
);
  logic [3:0] status;
  assign status = {hit_dm_o, hit_pred_o, hit_probe1_o, miss_o};

  assert_status_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones(status) == 1);

  assert_status_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> status == 4'b0000);

  // R2 R3 R6: single-cycle outcomes follow an accepted request
  assert_fast_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && (hit_dm_o || hit_pred_o || miss_o)) |-> $past(req_valid_i && req_ready_o));

  assert_probe1_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_probe1_o |-> ($past(!req_ready_o) && $past(req_valid_i && req_ready_o, 2)));

  assert_fill_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> !req_ready_o);

  assert_fill_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_o && fill_valid_i) |=> (!miss_valid_o && req_ready_o));

  assert_miss_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> miss_addr_o == $past(req_addr_i));

  assert_miss_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_o && !fill_valid_i) |=> (miss_valid_o && $stable(miss_addr_o)));
endmodule

bind rac_lookup rac_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .resp_valid_o,
  .hit_dm_o, .hit_pred_o, .hit_probe1_o, .miss_o, .miss_valid_o, .miss_addr_o,
  .fill_valid_i
);

// File: tb/sim_rac_lookup.sv
`timescale 1ns/1ps
module sim_rac_lookup;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WAYS   = 4;
  localparam int SETS   = 8;
  localparam int WAY_W  = 2;
  localparam int NVEC   = 18;

  // kind codes: 0 home-way hit, 1 guessed-way hit, 2 second probe, 3 miss
  // vector: {addr[11:0], pred[1:0], fill_assoc, fill_way[1:0], kind[1:0]}
  localparam logic [18:0] VECS [NVEC] = '{
    {12'h011, 2'd0, 1'b0, 2'd0, 2'd3},
    {12'h011, 2'd0, 1'b0, 2'd0, 2'd0},
    {12'h011, 2'd2, 1'b0, 2'd0, 2'd0},
    {12'h023, 2'd0, 1'b1, 2'd3, 2'd3},
    {12'h023, 2'd3, 1'b0, 2'd0, 2'd1},
    {12'h023, 2'd1, 1'b0, 2'd0, 2'd2},
    {12'h023, 2'd0, 1'b0, 2'd0, 2'd2},
    {12'h111, 2'd2, 1'b1, 2'd0, 2'd3},
    {12'h011, 2'd0, 1'b0, 2'd0, 2'd0},
    {12'h111, 2'd0, 1'b0, 2'd0, 2'd1},
    {12'h111, 2'd2, 1'b0, 2'd0, 2'd2},
    {12'h0FF, 2'd0, 1'b0, 2'd0, 2'd3},
    {12'h0FF, 2'd3, 1'b0, 2'd0, 2'd0},
    {12'h0FF, 2'd1, 1'b0, 2'd0, 2'd0},
    {12'h211, 2'd1, 1'b1, 2'd2, 2'd3},
    {12'h011, 2'd2, 1'b0, 2'd0, 2'd3},
    {12'h211, 2'd2, 1'b0, 2'd0, 2'd3},
    {12'h111, 2'd1, 1'b0, 2'd0, 2'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WAY_W-1:0]  req_pred = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_data;
  logic              hit_dm, hit_pred, hit_probe1, miss;
  logic              miss_valid;
  logic [ADDR_W-1:0] miss_addr;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              fill_assoc = 1'b0;
  logic [WAY_W-1:0]  fill_way = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rac_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_pred_way_i(req_pred),
    .resp_valid_o(resp_valid), .resp_data_o(resp_data),
    .hit_dm_o(hit_dm), .hit_pred_o(hit_pred), .hit_probe1_o(hit_probe1), .miss_o(miss),
    .miss_valid_o(miss_valid), .miss_addr_o(miss_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .fill_assoc_i(fill_assoc), .fill_way_i(fill_way)
  );

  function automatic logic [DATA_W-1:0] data_of(logic [ADDR_W-1:0] a);
    return {a, ~a, 8'h5A};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // issues one lookup; returns observed kind (4 = bad status), data, latency
  task automatic access(input logic [ADDR_W-1:0] a, input logic [WAY_W-1:0] p,
                        output int kind, output logic [DATA_W-1:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pred = p;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 4) begin
      @(posedge clk); #1;
      lat++;
    end
    chk("R9", "status one-hot", 32'($countones({hit_dm, hit_pred, hit_probe1, miss})),
        resp_valid ? 32'd1 : 32'd0);
    kind = hit_dm ? 0 : hit_pred ? 1 : hit_probe1 ? 2 : miss ? 3 : 4;
    d = resp_data;
  endtask

  task automatic do_fill(input logic [DATA_W-1:0] d, input logic as, input logic [WAY_W-1:0] w);
    @(negedge clk);
    fill_valid = 1'b1; fill_data = d; fill_assoc = as; fill_way = w;
    @(posedge clk); #1;
    fill_valid = 1'b0; fill_assoc = 1'b0;
    chk("R6", "fill releases miss_valid", 32'(miss_valid), 32'd0);
    chk("R6", "ready after fill", 32'(req_ready), 32'd1);
  endtask

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k, lat;
    logic [DATA_W-1:0] d;

    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ready in reset", 32'(req_ready), 32'd1);
    chk("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
    chk("R1", "miss_valid in reset", 32'(miss_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [ADDR_W-1:0] a;
      logic [WAY_W-1:0]  p, fw;
      logic              as;
      int                ek;
      {a, p, as, fw} = VECS[i][18:2];
      ek = int'(VECS[i][1:0]);
      access(a, p, k, d, lat);
      chk(tag_of(ek), $sformatf("vec %0d kind", i), 32'(k), 32'(ek));
      chk(tag_of(ek), $sformatf("vec %0d latency", i), 32'(lat), (ek == 2) ? 32'd2 : 32'd1);
      if (ek != 3) begin
        chk(tag_of(ek), $sformatf("vec %0d data", i), d, data_of(a));
      end else begin
        chk("R11", $sformatf("vec %0d miss addr", i), 32'(miss_addr), 32'(a));
        chk("R6", $sformatf("vec %0d miss_valid", i), 32'(miss_valid), 32'd1);
        do_fill(data_of(a), as, fw);
      end
      if (i == 2 || i == 8) chk("R4", "home way wins", 32'(k), 32'd0);
      if (i == 1 || i == 12) chk("R7", "default fill at home way", 32'(k), 32'd0);
      if (i == 4 || i == 9) chk("R8", "assoc fill at chosen way", 32'(k), 32'd1);
      if (i == 15) chk("R8", "assoc fill replaced line", 32'(k), 32'd3);
      if (i == 7) chk("R12", "alias of stored line misses", 32'(k), 32'd3);
    end

    // requests during a pending fill are dropped
    access(12'h3C5, 2'd1, k, d, lat);
    chk("R6", "3C5 miss", 32'(k), 32'd3);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h0FF; req_pred = 2'd3;
    for (int c = 0; c < 2; c++) begin
      @(posedge clk); #1;
      chk("R10", "no response while busy", 32'(resp_valid), 32'd0);
      chk("R11", "miss addr held", 32'(miss_addr), 32'h3C5);
    end
    req_valid = 1'b0;
    do_fill(data_of(12'h3C5), 1'b0, 2'd0);
    @(posedge clk); #1;
    chk("R10", "dropped request gives no late response", 32'(resp_valid), 32'd0);
    access(12'h3C5, 2'd1, k, d, lat);
    chk("R7", "3C5 at home way", 32'(k), 32'd0);
    chk("R7", "3C5 data", d, data_of(12'h3C5));

    // fill pulse while idle writes nothing
    @(negedge clk);
    fill_valid = 1'b1; fill_data = 32'hDEADBEEF; fill_assoc = 1'b0;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    chk("R10", "stray fill keeps ready", 32'(req_ready), 32'd1);
    access(12'h3C5, 2'd0, k, d, lat);
    chk("R10", "stray fill kind", 32'(k), 32'd0);
    chk("R10", "stray fill did not write", d, data_of(12'h3C5));

    // reset in mid-run clears all lines
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    chk("R1", "miss_valid after reset", 32'(miss_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    access(12'h0FF, 2'd3, k, d, lat);
    chk("R1", "lookup after reset misses", 32'(k), 32'd3);
    do_fill(data_of(12'h0FF), 1'b0, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule